// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Slice

This block is an 8-bit arithmetic slice with an explicit ripple carry chain. Each bit position forms a propagate term, a generate term and a sum bit. The carry leaving a bit either passes its incoming carry through or takes the generate value. The slice has two submodes. In the add/subtract submode it combines two operand buses. In the counter submode it steps a count held inside the slice by one, up or down. A single control line `op_i` sets the direction in both submodes. Logic 1 means add or count up, and logic 0 means subtract or count down.

The slice runs either across all eight bits or as a 4-bit nibble slice. In nibble mode only bits 3:0 take part in the carry chain and the result. The slice carry-out is then taken from bit 3. The count register can be preset from a parallel load bus. A registered copy of the carry-out is provided next to the combinational one.

Top module: `ripple_slice`

## Requirements
- R1: With mode_i=0 (add/subtract), op_i=1 and nibble_i=0, {cout_o, sum_o} equals a_i + b_i + cin_i as a 9-bit value, in the same cycle.
- R2: With mode_i=0, op_i=0 and nibble_i=0, sum_o equals (a_i - b_i) mod 256, and cout_o is 1 exactly when a_i >= b_i (1 means no borrow).
- R3: In subtract operation cin_i has no effect on sum_o or cout_o, because the carry into bit 0 is forced to 1.
- R4: With mode_i=1 (counter) and op_i=1, sum_o equals cnt_o + 1 (mod 2^active width), and cout_o is 1 exactly when the active bits of cnt_o are all ones.
- R5: With mode_i=1 and op_i=0, sum_o equals cnt_o - 1 (mod 2^active width), and cout_o is 0 exactly when the active bits of cnt_o are all zero.
- R6: On a rising clock edge with ld_i=0, cnt_o takes the sum_o value sampled at that edge when mode_i=1 and cnt_en_i=1. In every other case it holds its value.
- R7: On a rising clock edge with ld_i=1, cnt_o takes ld_data_i, whatever mode_i and cnt_en_i are.
- R8: cout_q_o equals the cout_o value sampled at the previous rising clock edge.
- R9: With nibble_i=1, sum_o[7:4] is 0, and {cout_o, sum_o[3:0]} is the 4-bit form of R1 to R5 on operand bits 3:0. Bits 7:4 of the operands and of cnt_o have no effect.
- R10: While rst_ni is 0, cnt_o and cout_q_o are 0.
- R11: In counter mode a_i, b_i and cin_i have no effect on sum_o or cout_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects add/subtract, 1 selects counter |
| op_i | input | 1 | 1 selects add or count up, 0 selects subtract or count down |
| nibble_i | input | 1 | 1 restricts the slice to bits 3:0 |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| cin_i | input | 1 | Carry into bit 0 (add operation only) |
| cnt_en_i | input | 1 | Count enable |
| ld_i | input | 1 | Load strobe for the count register |
| ld_data_i | input | 8 | Parallel preset value |
| sum_o | output | 8 | Result bus |
| cout_o | output | 1 | Combinational slice carry-out |
| cout_q_o | output | 1 | Registered carry-out |
| cnt_o | output | 8 | Present count |

## Verification
The result bus and the combinational carry-out are due in the same cycle as the operands. The bench drives inputs at the falling edge and samples these outputs a few nanoseconds later, before the next rising edge. The count register and the registered carry-out are due one rising edge later. They are sampled 1 ns after that edge and compared with a bench model that captured its expected values from the previous cycle's inputs. Nothing is compared at the edge itself.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
  typedef enum logic {
    MODE_ADDSUB = 1'b0,
    MODE_COUNT  = 1'b1
  } rs_mode_e;
endpackage

// File: rtl/rs_operand_mux.sv
module rs_operand_mux
  import ripple_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  rs_mode_e           mode_i,
  input  logic               op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               cin_i,
  input  logic [WIDTH-1:0]   cnt_i,
  output logic [WIDTH-1:0]   x_o,
  output logic [WIDTH-1:0]   y_o,
  output logic               c0_o
);
  always_comb begin
    if (mode_i == MODE_COUNT) begin
      // up: cnt + 0 + 1, down: cnt + all-ones + 0
      x_o  = cnt_i;
      y_o  = op_i ? '0 : '1;
      c0_o = op_i;
    end else begin
      // subtract as a + ~b + 1
      x_o  = a_i;
      y_o  = op_i ? b_i : ~b_i;
      c0_o = op_i ? cin_i : 1'b1;
    end
  end
endmodule

// File: rtl/rs_bit_cell.sv
module rs_bit_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  input  logic active_i,
  output logic s_o,
  output logic co_o
);
  logic prop, gen;

  assign prop = x_i ^ y_i;
  assign gen  = x_i & y_i;
  assign co_o = prop ? ci_i : gen;
  assign s_o  = active_i & (prop ^ ci_i);
endmodule

// File: rtl/rs_state_reg.sv
module rs_state_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_data_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] next_i,
  input  logic             cout_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             cout_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      cout_q_o <= 1'b0;
    end else begin
      cout_q_o <= cout_i;
      if (ld_i)        cnt_o <= ld_data_i;
      else if (step_i) cnt_o <= next_i;
    end
  end
endmodule

// File: rtl/ripple_slice.sv
module ripple_slice
  import ripple_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             op_i,
  input  logic             nibble_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             cnt_en_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_data_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             cout_q_o,
  output logic [WIDTH-1:0] cnt_o
);
  localparam int NIB_W = WIDTH / 2;

  rs_mode_e         mode;
  logic [WIDTH-1:0] x, y;
  logic [WIDTH:0]   carry;
  logic             step;

  assign mode = rs_mode_e'(mode_i);
  assign step = (mode == MODE_COUNT) & cnt_en_i;

  rs_operand_mux #(.WIDTH(WIDTH)) u_opmux (
    .mode_i (mode),
    .op_i   (op_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .cnt_i  (cnt_o),
    .x_o    (x),
    .y_o    (y),
    .c0_o   (carry[0])
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic active;
    if (i < NIB_W) begin : g_low
      assign active = 1'b1;
    end else begin : g_high
      assign active = ~nibble_i;
    end
    rs_bit_cell u_cell (
      .x_i      (x[i]),
      .y_i      (y[i]),
      .ci_i     (carry[i]),
      .active_i (active),
      .s_o      (sum_o[i]),
      .co_o     (carry[i+1])
    );
  end

  // nibble mode taps the chain after bit NIB_W-1
  assign cout_o = nibble_i ? carry[NIB_W] : carry[WIDTH];

  rs_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (ld_i),
    .ld_data_i (ld_data_i),
    .step_i    (step),
    .next_i    (sum_o),
    .cout_i    (cout_o),
    .cnt_o     (cnt_o),
    .cout_q_o  (cout_q_o)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             op_i,
  input logic             nibble_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic             cnt_en_i,
  input logic             ld_i,
  input logic [WIDTH-1:0] ld_data_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             cout_q_o,
  input logic [WIDTH-1:0] cnt_o
);
  localparam int NIB_W = WIDTH / 2;

  logic [WIDTH:0] add_ref;
  assign add_ref = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  p_add_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && op_i && !nibble_i) |-> ({cout_o, sum_o} == add_ref));

  p_sub_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !op_i && !nibble_i) |->
      ((sum_o == WIDTH'(a_i - b_i)) && (cout_o == (a_i >= b_i))));

  p_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && op_i && !nibble_i) |-> ((sum_o == WIDTH'(cnt_o + 1'b1)) && (cout_o == (&cnt_o))));

  p_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !op_i && !nibble_i) |-> ((sum_o == WIDTH'(cnt_o - 1'b1)) && (cout_o == (|cnt_o))));

  p_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && cnt_en_i && !ld_i) |=> (cnt_o == $past(sum_o)));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(mode_i && cnt_en_i)) |=> $stable(cnt_o));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_data_i)));

  p_coutq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (cout_q_o == $past(cout_o)));

  p_nib_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nibble_i |-> (sum_o[WIDTH-1:NIB_W] == '0));
endmodule

bind ripple_slice rs_checker #(.WIDTH(WIDTH)) u_rs_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .op_i      (op_i),
  .nibble_i  (nibble_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .cnt_en_i  (cnt_en_i),
  .ld_i      (ld_i),
  .ld_data_i (ld_data_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .cout_q_o  (cout_q_o),
  .cnt_o     (cnt_o)
);

// File: tb/ripple_slice_bench.sv
module ripple_slice_bench;
  localparam int MAX_CYCLES = 5000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b0, op_i = 1'b1, nibble_i = 1'b0, cin_i = 1'b0;
  logic       cnt_en_i = 1'b0, ld_i = 1'b0;
  logic [7:0] a_i = '0, b_i = '0, ld_data_i = '0;
  logic [7:0] sum_o, cnt_o;
  logic       cout_o, cout_q_o;

  int errors = 0;
  int checks = 0;
  logic [7:0] cnt_m = '0;
  logic       coutq_m = 1'b0;

  always #10 clk_i = ~clk_i;

  ripple_slice u_ripple_slice (
    .clk_i, .rst_ni, .mode_i, .op_i, .nibble_i, .a_i, .b_i, .cin_i,
    .cnt_en_i, .ld_i, .ld_data_i, .sum_o, .cout_o, .cout_q_o, .cnt_o
  );

  function automatic logic [8:0] model(input logic md, input logic op, input logic nib,
      input logic [7:0] a, input logic [7:0] b, input logic ci, input logic [7:0] cnt);
    logic [7:0] x, y;
    logic       c;
    logic [8:0] r;
    logic [4:0] rn;
    x = md ? cnt : a;
    y = md ? (op ? 8'h00 : 8'hFF) : (op ? b : ~b);
    c = md ? op : (op ? ci : 1'b1);
    if (nib) begin
      rn = {1'b0, x[3:0]} + {1'b0, y[3:0]} + {4'b0, c};
      r  = {rn[4], 4'b0, rn[3:0]};
    end else begin
      r = {1'b0, x} + {1'b0, y} + {8'b0, c};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check comb before posedge, registers 1 ns after it
  task automatic cycle(input string req, input logic md, input logic op, input logic nib,
      input logic [7:0] a, input logic [7:0] b, input logic ci,
      input logic en, input logic ld, input logic [7:0] ldd);
    logic [8:0] e;
    @(negedge clk_i);
    mode_i = md; op_i = op; nibble_i = nib; a_i = a; b_i = b; cin_i = ci;
    cnt_en_i = en; ld_i = ld; ld_data_i = ldd;
    #3;
    e = model(md, op, nib, a, b, ci, cnt_m);
    check(req, {7'b0, cout_o, sum_o}, {7'b0, e});
    @(posedge clk_i);
    #1;
    coutq_m = e[8];
    if (ld) cnt_m = ldd;
    else if (md && en) cnt_m = e[7:0];
    check({req, "/R8"}, {15'b0, cout_q_o}, {15'b0, coutq_m});
    check({req, "/R6 R7"}, {8'b0, cnt_o}, {8'b0, cnt_m});
  endtask

  initial begin
    #(MAX_CYCLES * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [8:0] e0, e1;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #2;
    check("R10 cnt", {8'b0, cnt_o}, 16'h0);
    check("R10 coutq", {15'b0, cout_q_o}, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 directed
    cycle("R1 wrap", 0, 1, 0, 8'hFF, 8'h01, 0, 0, 0, 8'h00);
    cycle("R1 cin", 0, 1, 0, 8'h7F, 8'h00, 1, 0, 0, 8'h00);
    // R2 directed
    cycle("R2 borrow", 0, 0, 0, 8'h05, 8'h07, 0, 0, 0, 8'h00);
    cycle("R2 equal", 0, 0, 0, 8'h42, 8'h42, 0, 0, 0, 8'h00);
    // R3: cin changes nothing in subtract
    @(negedge clk_i);
    mode_i = 0; op_i = 0; nibble_i = 0; a_i = 8'h30; b_i = 8'h11; cin_i = 0;
    #2; e0 = {cout_o, sum_o};
    cin_i = 1;
    #2; e1 = {cout_o, sum_o};
    check("R3", {7'b0, e1}, {7'b0, e0});
    check("R3 value", {7'b0, e1}, 16'h11F);
    // R9 nibble
    cycle("R9 carry", 0, 1, 1, 8'hFF, 8'h01, 0, 0, 0, 8'h00);
    cycle("R9 nocarry", 0, 1, 1, 8'h37, 8'h48, 0, 0, 0, 8'h00);
    cycle("R9 sub", 0, 0, 1, 8'hA2, 8'h53, 0, 0, 0, 8'h00);

    // R7 load beats counting
    cycle("R7 load", 1, 1, 0, 8'h00, 8'h00, 0, 1, 1, 8'hFE);
    cycle("R4 up", 1, 1, 0, 8'h00, 8'h00, 0, 1, 0, 8'h00);
    cycle("R4 wrap", 1, 1, 0, 8'h00, 8'h00, 0, 1, 0, 8'h00);
    cycle("R5 down zero", 1, 0, 0, 8'h00, 8'h00, 0, 1, 0, 8'h00);
    cycle("R5 down", 1, 0, 0, 8'h00, 8'h00, 0, 1, 0, 8'h00);
    cycle("R6 hold", 1, 1, 0, 8'h00, 8'h00, 0, 0, 0, 8'h00);
    cycle("R6 addmode hold", 0, 1, 0, 8'h12, 8'h34, 1, 1, 0, 8'h00);
    // R11 operands ignored in counter mode
    cycle("R11", 1, 1, 0, 8'hAA, 8'h55, 1, 0, 0, 8'h00);
    cycle("R11 b", 1, 1, 0, 8'h0F, 8'hF0, 0, 0, 0, 8'h00);
    // nibble counter: upper count bits ignored
    cycle("R9 R7 ld", 1, 1, 1, 8'h00, 8'h00, 0, 0, 1, 8'hAF);
    cycle("R9 R4 nib", 1, 1, 1, 8'h00, 8'h00, 0, 1, 0, 8'h00);
    cycle("R9 R5 nib", 1, 0, 1, 8'h00, 8'h00, 0, 1, 0, 8'h00);

    for (int k = 0; k < 300; k++) begin
      logic md, ld;
      md = 1'($urandom);
      ld = ($urandom % 8) == 0;
      cycle(md ? "R4 R5 rnd" : "R1 R2 rnd", md, 1'($urandom), 1'($urandom),
            8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), ld, 8'($urandom));
    end

    // R10 async reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R10 mid cnt", {8'b0, cnt_o}, 16'h0);
    check("R10 mid coutq", {15'b0, cout_q_o}, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule